// File: doc/BRIEF.md
# Escape-Coded Frame Extraction Decoder

This block sits behind a CPU extraction queue of a switch and turns its stream of 32-bit words back into frames, one at a time. Every frame starts with a fixed-length internal header, from which the block takes the source port number. After the header, control words sent in the same stream as the payload mark where the frame ends and how it ends. A word just after an escape word is always passed as data. The block removes the control words and delivers the payload words in order. With the last payload word it gives a byte count, an outcome (good, aborted or pruned) and the source port.

The input is a valid/ready word stream. The output is a valid-only stream with a last flag. It has no backpressure, so downstream logic must take one word per cycle. A static byte-swap select sets how words are matched against the control codes. The first beat of the next frame can follow right after the last beat of the current one.

Top module: `xtr_frame_decoder`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1. The first HDR_WORDS accepted words of each frame form the header and are never output. Header byte b is bits [31-8*(b%4) -: 8] of header word b/4. The source port is {header bytes 27..30 as a big-endian value} >> 5, bits 7:1. This equals bits [20:14] of header word 7.
- R2: After the header, any word that is not a control word is payload. Payload words come out on out_data in arrival order, and each one adds 4 to the byte count.
- R3: The control words are 0x80000000 to 0x80000007, matched on the compare word. A compare word of 0x80000000+x, with x from 0 to 3, ends the frame as good. The word before it is the last beat, and out_bytes = 4*N - x - 4, clamped at 0, where N is the number of payload words. At most one of out_good, out_abort and out_pruned is set.
- R4: An escape word (0x80000006) is not output. The word after it is payload, whatever its value.
- R5: A not-ready word (0x80000007) is dropped and does not change the frame.
- R6: After a pruned word (0x80000004), exactly one more word is taken as payload. That word is the last beat, with out_pruned=1, out_good=0 and out_bytes=4*N. in_ready then drops for exactly one cycle.
- R7: An abort word (0x80000005) ends the frame at once, with out_abort=1, out_good=0 and out_bytes=4*N. If the frame has no payload, a single last beat with out_data=0 and out_bytes=0 is produced.
- R8: When byte_swap_en=1, the compare word is the byte-reversed input word. Payload is still output exactly as it was received.
- R9: A source port at or above NUM_PORTS sets out_port_bad. A frame ended by 0x8000000x is then not marked good.
- R10: out_last is only set together with out_valid. out_good, out_abort, out_pruned, out_bytes, out_port and out_port_bad are zero on every beat that is not a last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_swap_en | input | 1 | Match control codes against the byte-reversed word |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input word |
| in_ready | output | 1 | Decoder accepts a word this cycle |
| out_valid | output | 1 | Payload beat valid |
| out_data | output | 32 | Payload word as received |
| out_last | output | 1 | Final beat of the frame |
| out_good | output | 1 | Frame ended normally on a valid port |
| out_abort | output | 1 | Frame was aborted |
| out_pruned | output | 1 | Frame was pruned |
| out_bytes | output | CNT_W | Frame byte count, valid on the last beat |
| out_port | output | PORT_W | Source port, valid on the last beat |
| out_port_bad | output | 1 | Source port out of range, valid on the last beat |

## Verification
A header counter that falls out of step shows up on the next frame. Header words then come out as payload, or the first payload word is swallowed, and the port is taken from the wrong word. This is visible on the first output beat of that frame. A wrong decoder state after an escape or pruned word gives a wrong word count or a missing last flag in the same frame. A missing or extra one-cycle stall on in_ready appears one cycle after the pruned frame's final payload word. A byte count slip shows up only on the last beat, which is why every frame outcome is checked with its exact count.

// File: rtl/xtr_pkg.sv
package xtr_pkg;
  localparam int WORD_W = 32;
  // Upper 29 bits shared by all eight control codes
  localparam logic [WORD_W-4:0] CODE_HI = 29'h1000_0000;

  typedef enum logic [2:0] {
    K_DATA  = 3'd0,
    K_EOF   = 3'd1,
    K_PRUNE = 3'd2,
    K_ABORT = 3'd3,
    K_ESC   = 3'd4,
    K_IDLE  = 3'd5
  } kind_e;

  typedef enum logic [2:0] {
    ST_HDR   = 3'd0,
    ST_BODY  = 3'd1,
    ST_ESC   = 3'd2,
    ST_PRUNE = 3'd3,
    ST_FLUSH = 3'd4
  } state_e;
endpackage

// File: rtl/xtr_code_classify.sv
module xtr_code_classify
  import xtr_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              swap_en,
  output kind_e             kind,
  output logic [1:0]        eof_lo
);
  localparam int NBYTES = WORD_W / 8;

  logic [WORD_W-1:0] swapped;
  logic [WORD_W-1:0] cmp;

  for (genvar b = 0; b < NBYTES; b++) begin : g_swap
    assign swapped[8*b +: 8] = word[WORD_W-8-8*b +: 8];
  end

  assign cmp    = swap_en ? swapped : word;
  assign eof_lo = cmp[1:0];

  always_comb begin
    kind = K_DATA;
    if (cmp[WORD_W-1:3] == CODE_HI) begin
      case (cmp[2:0])
        3'd4:    kind = K_PRUNE;
        3'd5:    kind = K_ABORT;
        3'd6:    kind = K_ESC;
        3'd7:    kind = K_IDLE;
        default: kind = K_EOF;
      endcase
    end
  end
endmodule

// File: rtl/xtr_hdr_capture.sv
module xtr_hdr_capture
  import xtr_pkg::*;
#(
  parameter int HDR_WORDS = 9,
  parameter int PORT_W    = 7,
  parameter int NUM_PORTS = 65
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [WORD_W-1:0] word,
  output logic              hdr_last,
  output logic [PORT_W-1:0] port,
  output logic              port_bad
);
  localparam int HC_W      = $clog2(HDR_WORDS + 1);
  localparam int PORT_WORD = 7;
  localparam int PORT_LSB  = 14;
  localparam logic [HC_W-1:0]   LAST_IDX  = HC_W'(HDR_WORDS - 1);
  localparam logic [HC_W-1:0]   PORT_IDX  = HC_W'(PORT_WORD);
  localparam logic [PORT_W:0]   PORT_LIM  = (PORT_W + 1)'(NUM_PORTS);

  logic [HC_W-1:0]   cnt_q, cnt_d;
  logic [PORT_W-1:0] port_q, port_d;

  assign hdr_last = (cnt_q == LAST_IDX);

  always_comb begin
    cnt_d  = cnt_q;
    port_d = port_q;
    if (take) begin
      cnt_d = hdr_last ? '0 : cnt_q + 1'b1;
      if (cnt_q == PORT_IDX) port_d = word[PORT_LSB +: PORT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      port_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      port_q <= port_d;
    end
  end

  assign port     = port_q;
  assign port_bad = ({1'b0, port_q} >= PORT_LIM);
endmodule

// File: rtl/xtr_frame_ctrl.sv
module xtr_frame_ctrl
  import xtr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  kind_e             kind,
  input  logic [1:0]        eof_lo,
  input  logic              hdr_last,
  input  logic              port_bad,
  output logic              in_ready,
  output logic              hdr_take,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last,
  output logic              out_good,
  output logic              out_abort,
  output logic              out_pruned,
  output logic [CNT_W-1:0]  out_bytes
);
  localparam logic [CNT_W-1:0] WORD_BYTES = CNT_W'(4);
  localparam logic [CNT_W-1:0] FCS_BYTES  = CNT_W'(4);

  state_e            st_q, st_d;
  logic [WORD_W-1:0] hold_q, hold_d;
  logic              hv_q, hv_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  logic              ov_d, ol_d, og_d, oa_d, op_d;
  logic [WORD_W-1:0] od_d;
  logic [CNT_W-1:0]  ob_d;

  logic              accept;
  logic              do_push;
  logic              do_end;
  logic [CNT_W-1:0]  trim;

  assign in_ready = (st_q != ST_FLUSH);
  assign accept   = in_valid && in_ready;
  assign trim     = CNT_W'(eof_lo) + FCS_BYTES;

  always_comb begin
    st_d     = st_q;
    hdr_take = 1'b0;
    do_push  = 1'b0;
    do_end   = 1'b0;
    og_d     = 1'b0;
    oa_d     = 1'b0;
    op_d     = 1'b0;
    ob_d     = '0;
    case (st_q)
      ST_HDR: begin
        hdr_take = accept;
        if (accept && hdr_last) st_d = ST_BODY;
      end
      ST_BODY: begin
        if (accept) begin
          case (kind)
            K_DATA:  do_push = 1'b1;
            K_ESC:   st_d = ST_ESC;
            K_PRUNE: st_d = ST_PRUNE;
            K_ABORT: begin
              do_end = 1'b1;
              oa_d   = 1'b1;
              ob_d   = cnt_q;
            end
            K_EOF: begin
              do_end = 1'b1;
              og_d   = !port_bad;
              ob_d   = (cnt_q >= trim) ? cnt_q - trim : '0;
            end
            default: ;
          endcase
        end
      end
      ST_ESC: begin
        if (accept) begin
          do_push = 1'b1;
          st_d    = ST_BODY;
        end
      end
      ST_PRUNE: begin
        if (accept) begin
          do_push = 1'b1;
          st_d    = ST_FLUSH;
        end
      end
      ST_FLUSH: begin
        do_end = 1'b1;
        op_d   = 1'b1;
        ob_d   = cnt_q;
      end
      default: st_d = ST_HDR;
    endcase
  end

  // Output word path: a payload word is held until the next word shows
  // whether it was the last one.
  always_comb begin
    hold_d = hold_q;
    hv_d   = hv_q;
    cnt_d  = cnt_q;
    ov_d   = 1'b0;
    ol_d   = 1'b0;
    od_d   = '0;
    if (do_push) begin
      ov_d   = hv_q;
      od_d   = hv_q ? hold_q : '0;
      hold_d = in_data;
      hv_d   = 1'b1;
      cnt_d  = cnt_q + WORD_BYTES;
    end else if (do_end) begin
      ov_d   = 1'b1;
      ol_d   = 1'b1;
      od_d   = hv_q ? hold_q : '0;
      hv_d   = 1'b0;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HDR;
      hold_q <= '0;
      hv_q   <= 1'b0;
      cnt_q  <= '0;
    end else begin
      st_q   <= (do_end) ? ST_HDR : st_d;
      hold_q <= hold_d;
      hv_q   <= hv_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_last   <= 1'b0;
      out_good   <= 1'b0;
      out_abort  <= 1'b0;
      out_pruned <= 1'b0;
      out_bytes  <= '0;
    end else begin
      out_valid  <= ov_d;
      out_data   <= od_d;
      out_last   <= ol_d;
      out_good   <= og_d;
      out_abort  <= oa_d;
      out_pruned <= op_d;
      out_bytes  <= ob_d;
    end
  end
endmodule

// File: rtl/xtr_frame_decoder.sv
module xtr_frame_decoder
  import xtr_pkg::*;
#(
  parameter int HDR_WORDS = 9,
  parameter int PORT_W    = 7,
  parameter int NUM_PORTS = 65,
  parameter int CNT_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_swap_en,
  input  logic              in_valid,
  input  logic [31:0]       in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [31:0]       out_data,
  output logic              out_last,
  output logic              out_good,
  output logic              out_abort,
  output logic              out_pruned,
  output logic [CNT_W-1:0]  out_bytes,
  output logic [PORT_W-1:0] out_port,
  output logic              out_port_bad
);
  kind_e             kind;
  logic [1:0]        eof_lo;
  logic              hdr_take;
  logic              hdr_last;
  logic [PORT_W-1:0] port;
  logic              port_bad;

  xtr_code_classify i_classify (
    .word    (in_data),
    .swap_en (byte_swap_en),
    .kind    (kind),
    .eof_lo  (eof_lo)
  );

  xtr_hdr_capture #(
    .HDR_WORDS (HDR_WORDS),
    .PORT_W    (PORT_W),
    .NUM_PORTS (NUM_PORTS)
  ) i_hdr (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (hdr_take),
    .word     (in_data),
    .hdr_last (hdr_last),
    .port     (port),
    .port_bad (port_bad)
  );

  xtr_frame_ctrl #(
    .CNT_W (CNT_W)
  ) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .kind       (kind),
    .eof_lo     (eof_lo),
    .hdr_last   (hdr_last),
    .port_bad   (port_bad),
    .in_ready   (in_ready),
    .hdr_take   (hdr_take),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_last   (out_last),
    .out_good   (out_good),
    .out_abort  (out_abort),
    .out_pruned (out_pruned),
    .out_bytes  (out_bytes)
  );

  assign out_port     = out_last ? port : '0;
  assign out_port_bad = out_last && port_bad;
endmodule

// File: rtl/xtr_frame_decoder_chk.sv
module xtr_frame_decoder_chk #(
  parameter int PORT_W    = 7,
  parameter int NUM_PORTS = 65,
  parameter int CNT_W     = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_last,
  input logic              out_good,
  input logic              out_abort,
  input logic              out_pruned,
  input logic [CNT_W-1:0]  out_bytes,
  input logic [PORT_W-1:0] out_port,
  input logic              out_port_bad
);
  localparam logic [PORT_W:0] LIM = (PORT_W + 1)'(NUM_PORTS);

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid); // R10
  AST_STATUS_ONLY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    !out_last |-> (!out_good && !out_abort && !out_pruned && out_bytes == '0 && out_port == '0 && !out_port_bad)); // R10
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_good, out_abort, out_pruned})); // R3
  AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready); // R6
  AST_STALL_ENDS_PRUNED: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> (out_last && out_pruned)); // R6
  AST_GOOD_PORT_OK: assert property (@(posedge clk) disable iff (!rst_n)
    out_good |-> (!out_port_bad && {1'b0, out_port} < LIM)); // R9
  AST_ABORT_WHOLE_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_abort |-> (out_bytes[1:0] == 2'b00)); // R7
endmodule

bind xtr_frame_decoder xtr_frame_decoder_chk #(
  .PORT_W    (PORT_W),
  .NUM_PORTS (NUM_PORTS),
  .CNT_W     (CNT_W)
) i_chk (.*);

// File: tb/test_xtr_frame_decoder.sv
`timescale 1ns/1ps
module test_xtr_frame_decoder;
  localparam int HDR = 9;
  localparam logic [31:0] C_EOF   = 32'h8000_0000;
  localparam logic [31:0] C_PRUNE = 32'h8000_0004;
  localparam logic [31:0] C_ABORT = 32'h8000_0005;
  localparam logic [31:0] C_ESC   = 32'h8000_0006;
  localparam logic [31:0] C_IDLE  = 32'h8000_0007;

  typedef struct packed {
    logic [3:0]  nw;
    logic [1:0]  endk;   // 0 eof, 1 pruned, 2 abort
    logic [1:0]  x;
    logic [6:0]  port;
    logic        swap;
    logic        idle;
    logic [15:0] exp_bytes;
    logic        exp_good;
    logic        exp_bad;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{4'd5, 2'd0, 2'd0, 7'd3,   1'b0, 1'b1, 16'd16, 1'b1, 1'b0},
    '{4'd4, 2'd0, 2'd3, 7'd12,  1'b1, 1'b0, 16'd9,  1'b1, 1'b0},
    '{4'd3, 2'd0, 2'd1, 7'd64,  1'b0, 1'b1, 16'd7,  1'b1, 1'b0},
    '{4'd6, 2'd1, 2'd0, 7'd5,   1'b0, 1'b1, 16'd24, 1'b0, 1'b0},
    '{4'd2, 2'd2, 2'd0, 7'd7,   1'b1, 1'b1, 16'd8,  1'b0, 1'b0},
    '{4'd3, 2'd0, 2'd2, 7'd100, 1'b0, 1'b0, 16'd6,  1'b0, 1'b1},
    '{4'd0, 2'd2, 2'd0, 7'd9,   1'b0, 1'b0, 16'd0,  1'b0, 1'b0},
    '{4'd1, 2'd0, 2'd0, 7'd1,   1'b0, 1'b0, 16'd0,  1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_swap_en = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready, out_valid, out_last, out_good, out_abort, out_pruned, out_port_bad;
  logic [31:0] out_data;
  logic [15:0] out_bytes;
  logic [6:0]  out_port;

  xtr_frame_decoder i_xtr_frame_decoder (
    .clk(clk), .rst_n(rst_n), .byte_swap_en(byte_swap_en),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_good(out_good), .out_abort(out_abort), .out_pruned(out_pruned),
    .out_bytes(out_bytes), .out_port(out_port), .out_port_bad(out_port_bad)
  );

  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // beat capture
  int          nbeats = 0;
  int          stalls = 0;
  logic [31:0] b_data [32];
  logic        b_last [32];
  logic [15:0] b_bytes [32];
  logic [5:0]  b_stat [32];  // good, abort, pruned, bad, unused
  logic [6:0]  b_port [32];
  logic [31:0] exp_pay [32];
  int          exp_n = 0;

  always @(negedge clk) begin
    if (rst_n && !in_ready) stalls++;
    if (rst_n && out_valid && nbeats < 32) begin
      b_data[nbeats]  = out_data;
      b_last[nbeats]  = out_last;
      b_bytes[nbeats] = out_bytes;
      b_stat[nbeats]  = {2'b00, out_good, out_abort, out_pruned, out_port_bad};
      b_port[nbeats]  = out_port;
      nbeats++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] bsw(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic put(input logic [31:0] w);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic put_code(input logic [31:0] c);
    put(byte_swap_en ? bsw(c) : c);
  endtask

  task automatic put_data(input logic [31:0] w);
    put(w);
    exp_pay[exp_n] = w;
    exp_n++;
  endtask

  task automatic start_frame(input logic [6:0] port);
    nbeats = 0;
    stalls = 0;
    exp_n  = 0;
    for (int i = 0; i < HDR; i++)
      put(i == 7 ? {11'd0, port, 14'd0} : (32'hC0DE_0000 | 32'(i)));
  endtask

  // compare captured beats against expected payload and last-beat status
  task automatic check_frame(input string req, input logic [15:0] bytes,
                             input logic [3:0] stat, input logic [6:0] port);
    int ne;
    repeat (3) @(negedge clk);
    ne = (exp_n == 0) ? 1 : exp_n;
    chk(nbeats == ne, {req, " beat count"}, nbeats, ne);
    if (nbeats == ne) begin
      for (int i = 0; i < ne; i++) begin
        chk(b_data[i] == ((exp_n == 0) ? 32'h0 : exp_pay[i]), {req, " R2 data"}, b_data[i],
            (exp_n == 0) ? 32'h0 : exp_pay[i]);
        chk(b_last[i] == (i == ne - 1), {req, " R10 last flag"}, b_last[i], (i == ne - 1));
      end
      chk(b_bytes[ne-1] == bytes, {req, " byte count"}, b_bytes[ne-1], bytes);
      chk(b_stat[ne-1][3:0] == stat, {req, " status"}, b_stat[ne-1][3:0], stat);
      chk(b_port[ne-1] == port, {req, " R1 port"}, b_port[ne-1], port);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R1 reset in_ready", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // table of frames
    for (int f = 0; f < 8; f++) begin
      vec_t v;
      string tag;
      v = VECS[f];
      byte_swap_en = v.swap;
      start_frame(v.port);
      for (int i = 0; i < int'(v.nw); i++) begin
        if (v.endk == 2'd1 && i == int'(v.nw) - 1) put_code(C_PRUNE);
        put_data(32'h1234_5600 | 32'(f * 16 + i));
        if (v.idle && i == 0) put_code(C_IDLE); // R5
      end
      if (v.endk == 2'd0) put_code(C_EOF | 32'(v.x));
      if (v.endk == 2'd2) put_code(C_ABORT);
      case (v.endk)
        2'd0: tag = v.exp_bad ? "R9" : "R3";
        2'd1: tag = "R6";
        default: tag = "R7";
      endcase
      if (v.swap) tag = {tag, "/R8"};
      if (v.idle) tag = {tag, "/R5"};
      check_frame(tag, v.exp_bytes,
                  {v.exp_good, v.endk == 2'd2, v.endk == 2'd1, v.exp_bad}, v.port);
      if (v.endk == 2'd1) chk(stalls == 1, "R6 one stall cycle", stalls, 1);
      else chk(stalls == 0, "R6 no stall", stalls, 0);
    end

    // R4: escaped code values pass as data
    byte_swap_en = 1'b0;
    start_frame(7'd20);
    put_data(32'h0BAD_F00D);
    put_code(C_ESC);
    put_data(C_ABORT);
    put_code(C_ESC);
    put_data(C_ESC);
    put_data(32'h0000_0080);
    put_code(C_EOF | 32'd2);
    check_frame("R4", 16'd10, 4'b1000, 7'd20);

    // R8: with swap on, unswapped code values are plain data
    byte_swap_en = 1'b1;
    start_frame(7'd33);
    put_data(C_EOF | 32'd1);
    put_data(C_IDLE);
    put_code(C_EOF);
    check_frame("R8", 16'd4, 4'b1000, 7'd33);

    // R3: short good frame clamps the count at zero
    byte_swap_en = 1'b0;
    start_frame(7'd2);
    put_data(32'h5555_AAAA);
    put_code(C_EOF | 32'd3);
    check_frame("R3 clamp", 16'd0, 4'b1000, 7'd2);

    // R6: pruned right after header keeps only the extra word
    start_frame(7'd4);
    put_code(C_PRUNE);
    put_data(C_ABORT);
    check_frame("R6 lone", 16'd4, 4'b0010, 7'd4);
    chk(stalls == 1, "R6 lone stall", stalls, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule